// File: doc/BRIEF.md
# Oversampling UART Receiver with Mid-Frame Realignment

This block turns an asynchronous serial line into parallel characters. A sample enable runs at sixteen times the bit rate. On every enabled clock the receiver takes one sample of the line, and a slot counter splits each bit period into sixteen slots. A bit is decided by a two-of-three vote over the samples in the three middle slots. The counter is aligned to the falling edge that begins the start bit. It is re-phased inside the frame whenever a data bit that voted 1 is followed by a data bit that votes 0, so that moderate mismatch between the sender's rate and the local rate is absorbed.

A character carries 8 or 9 data bits, least significant bit first, followed by one stop bit. A finished character moves into a read-only holding buffer and sets a full flag. The ninth-bit register holds data bit 8 in 9-bit mode and repeats data bit 7 in 8-bit mode. A read strobe empties the buffer. The interrupt request follows the full flag when it is enabled. Framing and overrun conditions are flagged next to the data.

Top module: `oversamp_uart_rx`

## Requirements
- R1: The line is sampled only on clocks where `sample_tick` is high. Each bit period spans 16 samples, numbered slot 1 to slot 16. A bit's value is the majority of the samples at slots 8, 9 and 10, so a single inverted sample among them does not change the bit.
- R2: A start is accepted only on a sample that is 0 when the previous sample was 1, and only if at least three consecutive 1 samples came just before it. A falling edge after fewer high samples, as seen after reset, is ignored.
- R3: If the start bit votes 1, the start is dropped as false and the receiver goes back to waiting for an edge without producing a character.
- R4: The slot counter is set to slot 1 on the accepted start sample, so the timing of a character is independent of the idle time before it.
- R5: When a data bit votes 0 and the previous data bit voted 1, the slot counter is re-phased so that the latest 1-to-0 sample becomes slot 1 (accepted when that edge lies 4 to 15 samples back). With this, frames sent with bits 15 or 18 samples long and alternating data are received correctly.
- R6: With `nine_bit_mode` = 0 a character has 8 data bits, LSB first. `rx_data` gets bits 7..0 and `rx_bit9` gets a copy of data bit 7.
- R7: With `nine_bit_mode` = 1 a character has 9 data bits, LSB first. `rx_data` gets bits 7..0 and `rx_bit9` gets data bit 8.
- R8: After reset, `rx_full`, `overrun` and `framing_err` are 0. When the stop bit has been voted, the data is loaded into the buffer and `rx_full` becomes 1.
- R9: `rx_irq` is 1 exactly when `rx_full` is 1 and `rx_irq_en` is 1.
- R10: `framing_err` is loaded with 1 when the stop bit votes 0 and with 0 otherwise. The data is transferred in both cases.
- R11: A character that finishes while `rx_full` is still 1 sets `overrun` and leaves `rx_data` and `rx_bit9` unchanged.
- R12: A one-clock `rd_strobe` clears `rx_full` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| nine_bit_mode | input | 1 | 1: nine data bits, 0: eight |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Buffer read strobe, one clock |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit9 | output | 1 | Ninth-bit register |
| rx_full | output | 1 | Buffer holds an unread character |
| framing_err | output | 1 | Stop bit of the buffered character voted 0 |
| overrun | output | 1 | A character was lost while the buffer was full |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
On every cycle the assertions check the following: the slot counter stays in range, a start is taken only when the edge detector reports one and always begins at slot 1, a false start returns to idle, the buffer flags react correctly to a load or a read, and the interrupt stays low while it is disabled. Only the bench's scenarios can show that the voted bits form the right character. This covers a glitch inside the vote window, the 8-bit and 9-bit layouts with their ninth-bit rule, and frames whose bits are too long or too short, where the mid-frame re-phasing is what keeps the result correct.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   // two-of-three vote over the centre samples of a bit
   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uartrx_line_watch.sv
// Tracks line history on sample ticks: idle run length and distance to the
// most recent falling edge.
module uartrx_line_watch #(
   parameter int OVS      = 16,
   parameter int IDLE_RUN = 3,
   localparam int SLOT_W  = $clog2(OVS + 1),
   localparam int RUN_W   = $clog2(IDLE_RUN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic              start_hit,
   output logic [SLOT_W-1:0] since_nxt
);

   localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(OVS);
   localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(IDLE_RUN);

   logic              prev_q;
   logic [RUN_W-1:0]  run_q;
   logic [SLOT_W-1:0] since_q;
   logic              fall;

   assign fall      = prev_q & ~rxd;
   assign start_hit = tick & fall & (run_q >= RUN_MAX);

   always_comb begin
      if (fall)
         since_nxt = SLOT_W'(1);
      else if (since_q == SLOT_MAX)
         since_nxt = since_q;
      else
         since_nxt = since_q + SLOT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         run_q   <= '0;
         since_q <= SLOT_MAX;
      end else if (tick) begin
         prev_q  <= rxd;
         since_q <= since_nxt;
         if (!rxd)
            run_q <= '0;
         else if (run_q != RUN_MAX)
            run_q <= run_q + RUN_W'(1);
      end
   end

endmodule

// File: rtl/uartrx_frame_seq.sv
// Frame sequencer: slot counter, centre-sample vote, start/data/stop walk,
// mid-frame re-phasing and shift register.
module uartrx_frame_seq
   import uartrx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int RESYNC_LO = 4,
   parameter int RESYNC_HI = 15,
   localparam int SLOT_W   = $clog2(OVS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              nine_mode,
   input  logic              start_hit,
   input  logic [SLOT_W-1:0] since_nxt,
   output logic              done,
   output logic              stop_ok,
   output logic [8:0]        shreg,
   output rx_state_e         st,
   output logic              vote_fire,
   output logic              vote_val,
   output logic [SLOT_W-1:0] slot
);

   localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(OVS);
   localparam logic [SLOT_W-1:0] SLOT_A   = SLOT_W'(OVS / 2);
   localparam logic [SLOT_W-1:0] SLOT_B   = SLOT_W'(OVS / 2 + 1);
   localparam logic [SLOT_W-1:0] SLOT_C   = SLOT_W'(OVS / 2 + 2);
   localparam logic [SLOT_W-1:0] RS_LO    = SLOT_W'(RESYNC_LO);
   localparam logic [SLOT_W-1:0] RS_HI    = SLOT_W'(RESYNC_HI);

   rx_state_e         st_q;
   logic [SLOT_W-1:0] slot_q, slot_inc;
   logic              voted_q, sa_q, sb_q, prev_one_q;
   logic [3:0]        idx_q, last_idx;
   logic              resync;

   assign st       = st_q;
   assign slot     = slot_q;
   assign slot_inc = (slot_q == SLOT_MAX) ? SLOT_W'(1) : slot_q + SLOT_W'(1);
   assign last_idx = nine_mode ? 4'd8 : 4'd7;

   assign vote_fire = tick & (st_q != RX_IDLE) & (slot_inc == SLOT_C) & ~voted_q;
   assign vote_val  = maj3(sa_q, sb_q, rxd);
   assign resync    = (st_q == RX_DATA) & prev_one_q & ~vote_val
                      & (since_nxt >= RS_LO) & (since_nxt <= RS_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         slot_q     <= SLOT_W'(1);
         voted_q    <= 1'b0;
         sa_q       <= 1'b1;
         sb_q       <= 1'b1;
         prev_one_q <= 1'b0;
         idx_q      <= '0;
         shreg      <= '0;
         done       <= 1'b0;
         stop_ok    <= 1'b1;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (st_q == RX_IDLE) begin
               if (start_hit) begin
                  st_q       <= RX_START;
                  slot_q     <= SLOT_W'(1);
                  voted_q    <= 1'b0;
                  prev_one_q <= 1'b0;
                  idx_q      <= '0;
                  shreg      <= '0;
               end
            end else begin
               slot_q <= slot_inc;
               if (slot_inc == SLOT_W'(1)) voted_q <= 1'b0;
               if (slot_inc == SLOT_A) sa_q <= rxd;
               if (slot_inc == SLOT_B) sb_q <= rxd;
               if (vote_fire) begin
                  voted_q <= 1'b1;
                  unique case (st_q)
                     RX_START: st_q <= vote_val ? RX_IDLE : RX_DATA;
                     RX_DATA: begin
                        shreg[idx_q] <= vote_val;
                        prev_one_q   <= vote_val;
                        if (resync) slot_q <= since_nxt;
                        if (idx_q == last_idx) st_q <= RX_STOP;
                        else idx_q <= idx_q + 4'd1;
                     end
                     RX_STOP: begin
                        st_q    <= RX_IDLE;
                        done    <= 1'b1;
                        stop_ok <= vote_val;
                     end
                     default: st_q <= RX_IDLE;
                  endcase
               end
            end
         end
      end
   end

endmodule

// File: rtl/uartrx_hold_buf.sv
// Read-only holding buffer with full, framing and overrun flags.
module uartrx_hold_buf (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       stop_ok,
   input  logic [8:0] shreg,
   input  logic       nine_mode,
   input  logic       rd,
   output logic [7:0] data,
   output logic       bit9,
   output logic       full,
   output logic       ferr,
   output logic       ovr
);

   logic busy;
   assign busy = full & ~rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         bit9 <= 1'b0;
         full <= 1'b0;
         ferr <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (rd) begin
            full <= 1'b0;
            ovr  <= 1'b0;
         end
         if (load) begin
            if (busy) begin
               ovr <= 1'b1;
            end else begin
               data <= shreg[7:0];
               bit9 <= nine_mode ? shreg[8] : shreg[7];
               full <= 1'b1;
               ferr <= ~stop_ok;
            end
         end
      end
   end

endmodule

// File: rtl/oversamp_uart_rx.sv
module oversamp_uart_rx
   import uartrx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int IDLE_RUN  = 3,
   parameter int RESYNC_LO = 4,
   parameter int RESYNC_HI = 15,
   localparam int SLOT_W   = $clog2(OVS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_tick,
   input  logic       rxd,
   input  logic       nine_bit_mode,
   input  logic       rx_irq_en,
   input  logic       rd_strobe,
   output logic [7:0] rx_data,
   output logic       rx_bit9,
   output logic       rx_full,
   output logic       framing_err,
   output logic       overrun,
   output logic       rx_irq
);

   generate
      if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 8");
      end
      if (IDLE_RUN < 1) begin : g_bad_run
         $error("IDLE_RUN must be at least 1");
      end
      if (RESYNC_LO < 1 || RESYNC_HI > OVS || RESYNC_LO > RESYNC_HI) begin : g_bad_window
         $error("re-phase window must lie within 1..OVS");
      end
   endgenerate

   logic              start_hit_w;
   logic [SLOT_W-1:0] since_w;
   logic              done_w, stop_ok_w, vote_fire_w, vote_val_w;
   logic [8:0]        shreg_w;
   rx_state_e         st_w;
   logic [SLOT_W-1:0] slot_w;

   uartrx_line_watch #(.OVS(OVS), .IDLE_RUN(IDLE_RUN)) i_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rxd       (rxd),
      .start_hit (start_hit_w),
      .since_nxt (since_w)
   );

   uartrx_frame_seq #(.OVS(OVS), .RESYNC_LO(RESYNC_LO), .RESYNC_HI(RESYNC_HI)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rxd       (rxd),
      .nine_mode (nine_bit_mode),
      .start_hit (start_hit_w),
      .since_nxt (since_w),
      .done      (done_w),
      .stop_ok   (stop_ok_w),
      .shreg     (shreg_w),
      .st        (st_w),
      .vote_fire (vote_fire_w),
      .vote_val  (vote_val_w),
      .slot      (slot_w)
   );

   uartrx_hold_buf i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (done_w),
      .stop_ok   (stop_ok_w),
      .shreg     (shreg_w),
      .nine_mode (nine_bit_mode),
      .rd        (rd_strobe),
      .data      (rx_data),
      .bit9      (rx_bit9),
      .full      (rx_full),
      .ferr      (framing_err),
      .ovr       (overrun)
   );

   assign rx_irq = rx_full & rx_irq_en;

endmodule

// File: rtl/oversamp_uart_rx_chk.sv
module oversamp_uart_rx_chk
   import uartrx_pkg::*;
#(
   parameter int OVS     = 16,
   localparam int SLOT_W = $clog2(OVS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_strobe,
   input logic              rx_irq_en,
   input logic [7:0]        rx_data,
   input logic              rx_full,
   input logic              framing_err,
   input logic              overrun,
   input logic              rx_irq,
   input logic              done,
   input logic              start_hit,
   input rx_state_e         st,
   input logic              vote_fire,
   input logic              vote_val,
   input logic [SLOT_W-1:0] slot
);

   // R1: slot counter stays within one bit period while a frame is active
   a_r1_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st != RX_IDLE) |-> (slot >= SLOT_W'(1) && slot <= SLOT_W'(OVS)));

   // R2: idle is left only when the edge detector reports a valid start
   a_r2_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && !start_hit) |=> (st == RX_IDLE));

   // R4: an accepted start begins at slot 1
   a_r4_start_at_slot1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && start_hit) |=> (st == RX_START && slot == SLOT_W'(1)));

   // R3: start bit voting 1 returns to idle
   a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
      (vote_fire && st == RX_START && vote_val) |=> (st == RX_IDLE));

   // R8: a load into an empty buffer sets the full flag
   a_r8_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rx_full) |=> rx_full);

   // R9: no interrupt while disabled
   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |-> !rx_irq);

   // R10: framing flag changes only on a load
   a_r10_ferr_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(framing_err) |-> $past(done));

   // R11: overrun keeps the buffered data
   a_r11_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full && !rd_strobe) |=> (overrun && $stable(rx_data)));

   // R12: a read empties the buffer when nothing arrives at the same time
   a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !done) |=> (!rx_full && !overrun));

endmodule

bind oversamp_uart_rx oversamp_uart_rx_chk #(.OVS(OVS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_strobe   (rd_strobe),
   .rx_irq_en   (rx_irq_en),
   .rx_data     (rx_data),
   .rx_full     (rx_full),
   .framing_err (framing_err),
   .overrun     (overrun),
   .rx_irq      (rx_irq),
   .done        (done_w),
   .start_hit   (start_hit_w),
   .st          (st_w),
   .vote_fire   (vote_fire_w),
   .vote_val    (vote_val_w),
   .slot        (slot_w)
);

// File: tb/test_oversamp_uart_rx.sv
`timescale 1ns/1ps
module test_oversamp_uart_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic       rx_irq_en = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_full, framing_err, overrun, rx_irq;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   oversamp_uart_rx i_oversamp_uart_rx (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
      .nine_bit_mode(nine_bit_mode), .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
      .framing_err(framing_err), .overrun(overrun), .rx_irq(rx_irq)
   );

   // {nine, data[8:0], stop, samples per bit[4:0]}
   localparam logic [15:0] VEC [0:6] = '{
      {1'b0, 9'h0A5, 1'b1, 5'd16},
      {1'b0, 9'h03C, 1'b1, 5'd16},
      {1'b1, 9'h15A, 1'b1, 5'd16},
      {1'b1, 9'h0FF, 1'b1, 5'd16},
      {1'b0, 9'h055, 1'b1, 5'd18},
      {1'b0, 9'h081, 1'b0, 5'd16},
      {1'b0, 9'h055, 1'b1, 5'd15}
   };

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic v);
      @(negedge clk);
      rxd = v;
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
   endtask

   task automatic send_frame(input bit nine, input logic [8:0] d, input bit stop,
                             input int len, input int gbit, input int gsamp);
      repeat (4) step(1'b1);
      repeat (len) step(1'b0);
      for (int b = 0; b < (nine ? 9 : 8); b++)
         for (int s = 1; s <= len; s++)
            step((b == gbit && s == gsamp) ? ~d[b] : d[b]);
      repeat (len) step(stop);
      repeat (6) step(1'b1);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   logic [15:0] v;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      chk("R8 reset full", rx_full, 0);
      chk("R8 reset overrun", overrun, 0);
      chk("R8 reset ferr", framing_err, 0);
      chk("R9 reset irq", rx_irq, 0);

      // table: R4 (start alignment each frame), R5 (15/18-sample bits),
      // R6/R7 layouts, R10 stop handling, R12 read
      for (int i = 0; i < 7; i++) begin
         v = VEC[i];
         nine_bit_mode = v[15];
         send_frame(v[15], v[14:6], v[5], int'(v[4:0]), -1, 0);
         chk($sformatf("R8 vec%0d full", i), rx_full, 1);
         chk($sformatf("R6 R7 R5 R4 vec%0d data", i), rx_data, v[13:6]);
         chk($sformatf("R6 R7 vec%0d bit9", i), rx_bit9, v[15] ? v[14] : v[13]);
         chk($sformatf("R10 vec%0d ferr", i), framing_err, v[5] ? 0 : 1);
         do_read();
         chk($sformatf("R12 vec%0d cleared", i), rx_full, 0);
      end
      nine_bit_mode = 1'b0;

      // R1: one flipped sample inside the vote window
      send_frame(1'b0, 9'h03C, 1'b1, 16, 3, 9);
      chk("R1 glitch slot9", rx_data, 8'h3C);
      do_read();
      send_frame(1'b0, 9'h03C, 1'b1, 16, 6, 10);
      chk("R1 glitch slot10", rx_data, 8'h3C);
      do_read();

      // R9: interrupt gating
      rx_irq_en = 1'b0;
      send_frame(1'b0, 9'h012, 1'b1, 16, -1, 0);
      chk("R9 irq disabled", rx_irq, 0);
      @(negedge clk);
      rx_irq_en = 1'b1;
      @(negedge clk);
      chk("R9 irq enabled", rx_irq, 1);
      do_read();
      chk("R9 irq after read", rx_irq, 0);
      rx_irq_en = 1'b0;

      // R11: overrun keeps first character
      send_frame(1'b0, 9'h021, 1'b1, 16, -1, 0);
      send_frame(1'b0, 9'h042, 1'b1, 16, -1, 0);
      chk("R11 overrun set", overrun, 1);
      chk("R11 data kept", rx_data, 8'h21);
      chk("R11 still full", rx_full, 1);
      do_read();
      chk("R12 full cleared", rx_full, 0);
      chk("R12 overrun cleared", overrun, 0);

      // R3: false start pulse, then a valid frame
      repeat (4) step(1'b1);
      repeat (5) step(1'b0);
      repeat (40) step(1'b1);
      chk("R3 false start no char", rx_full, 0);
      send_frame(1'b0, 9'h099, 1'b1, 16, -1, 0);
      chk("R3 recovers", rx_data, 8'h99);
      do_read();

      // R2: edge after only two high samples following reset is ignored
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) step(1'b1);
      repeat (16) step(1'b0);
      repeat (200) step(1'b1);
      chk("R2 short idle ignored", rx_full, 0);
      send_frame(1'b0, 9'h0C3, 1'b1, 16, -1, 0);
      chk("R2 normal start", rx_data, 8'hC3);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule